// File: doc/BRIEF.md
# PCI Interrupt Router

This block takes an interrupt event from a device on the PCI bus and turns it into the single interrupt line that reaches the processor. The device is named by its device/function number and by the interrupt pin it asserts, in the range 0 to 3. A fixed slot table maps each slot and pin onto one of a bank of internal interrupt lines that are numbered from a base of 32. The routed line number is presented combinationally on `line_o`.

The routed line, less the base, gives an index into two configuration words. One word selects edge or level behaviour for each line. The other gives each line its polarity. When an event strobe arrives on a line in edge mode, the processor output gives a one-clock pulse. When it arrives on a line in level mode, the output is driven to that line's polarity bit and is held there. If the routed line falls outside the bank, the event has no effect.

Top module: `pci_irq_router`

## Requirements
- R1: After reset `irq_o` is low.
- R2: The slot number is `devfn_i[7:3]`. The function bits `devfn_i[2:0]` have no effect on `line_o`.
- R3: Slot 5 routes pin p to line 32 + p.
- R4: Slot 6 routes to line 36 and slot 7 routes to line 37, whatever the pin.
- R5: Slots 8 to 12 route pin p to line 38 + (slot - 8) + p, so every such line lies in the range 38 to 45.
- R6: Every other slot passes the pin through, so `line_o` equals `pin_i`.
- R7: The index is `line_o` - 32 and it selects bit [index] of `edge_cfg_i` and of `pol_cfg_i`. A strobe on `evt_i` at an edge with the selected edge bit at 1 drives `irq_o` high for exactly the one following cycle, after which it is low.
- R8: While an edge pulse is being emitted, a strobe is ignored. The pulse is not lengthened and `irq_o` is low in the cycle after it.
- R9: A strobe with the selected edge bit at 0 sets `irq_o`, from the next cycle on, to the selected polarity bit (1 means high, 0 means low).
- R10: A strobe whose routed line is below 32 or above 63 leaves `irq_o` unchanged.
- R11: When no strobe is accepted and no pulse is in progress, `irq_o` holds its value, even when the configuration words change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| devfn_i | input | 8 | Device/function number of the requesting device |
| pin_i | input | 2 | Interrupt pin index, 0 to 3 |
| evt_i | input | 1 | Interrupt event strobe, one per cycle when high |
| edge_cfg_i | input | 32 | Per-line edge-mode bits, bit n for line 32 + n |
| pol_cfg_i | input | 32 | Per-line level polarity bits, bit n for line 32 + n |
| line_o | output | 6 | Routed interrupt line number |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The assertions assume that `devfn_i`, `pin_i` and both configuration words are steady around each clock edge at which `evt_i` is sampled. They also assume that the pin index never exceeds 3. The bench changes every input only on the falling edge and draws pin values from 0 to 3 only. It reconfigures the edge and polarity words only between events, so that a level-mode result always traces back to a single known polarity bit.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int DEVFN_W  = 8;
  localparam int SLOT_W   = 5;
  typedef logic [SLOT_W-1:0] slot_t;

  // slot table
  localparam slot_t SLOT_SB     = 5'd5;
  localparam slot_t SLOT_GFX    = 5'd6;
  localparam slot_t SLOT_NIC    = 5'd7;
  localparam slot_t SLOT_EXP_LO = 5'd8;
  localparam slot_t SLOT_EXP_HI = 5'd12;

  // line offsets above the bank base
  localparam int OFS_GFX = 4;
  localparam int OFS_NIC = 5;
  localparam int OFS_EXP = 6;
endpackage

// File: rtl/pir_route.sv
module pir_route
  import pir_pkg::*;
#(
  parameter int LINE_BASE = 32,
  parameter int LINE_W    = 6,
  parameter int PIN_W     = 2
) (
  input  slot_t             slot_i,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [LINE_W-1:0] BASE_L = LINE_W'(LINE_BASE);
  localparam logic [LINE_W-1:0] EXP_LO = LINE_W'(LINE_BASE + OFS_EXP);
  localparam logic [LINE_W-1:0] EXP_HI =
    LINE_W'(LINE_BASE + OFS_EXP + int'(SLOT_EXP_HI - SLOT_EXP_LO) + 3);

  logic [LINE_W-1:0] pin_mod;
  logic [LINE_W-1:0] pin_ext;
  logic              exp_slot;

  assign pin_mod  = LINE_W'(pin_i[1:0]);
  assign pin_ext  = LINE_W'(pin_i);
  assign exp_slot = (slot_i >= SLOT_EXP_LO) && (slot_i <= SLOT_EXP_HI);

  always_comb begin
    if (slot_i == SLOT_SB)       line_o = BASE_L + pin_mod;
    else if (slot_i == SLOT_GFX) line_o = BASE_L + LINE_W'(OFS_GFX);
    else if (slot_i == SLOT_NIC) line_o = BASE_L + LINE_W'(OFS_NIC);
    else if (exp_slot)
      line_o = BASE_L + LINE_W'(OFS_EXP) + LINE_W'(slot_i - SLOT_EXP_LO) + pin_ext;
    else                         line_o = pin_ext;
  end

  // R5
  always_comb begin
    if (exp_slot && pin_i <= PIN_W'(3)) begin
      exp_line_range_chk: assert (line_o >= EXP_LO && line_o <= EXP_HI);
    end
  end
endmodule

// File: rtl/pir_cfg_sel.sv
module pir_cfg_sel #(
  parameter int LINE_BASE = 32,
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = 6
) (
  input  logic [LINE_W-1:0]    line_i,
  input  logic [NUM_LINES-1:0] edge_cfg_i,
  input  logic [NUM_LINES-1:0] pol_cfg_i,
  output logic                 valid_o,
  output logic                 edge_o,
  output logic                 pol_o
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [LINE_W-1:0] BASE_L = LINE_W'(LINE_BASE);

  logic [LINE_W-1:0] ofs;
  logic [IDX_W-1:0]  idx;

  assign ofs     = line_i - BASE_L;
  assign idx     = ofs[IDX_W-1:0];
  assign valid_o = (line_i >= BASE_L) && ({1'b0, ofs} < (LINE_W+1)'(NUM_LINES));
  assign edge_o  = valid_o & edge_cfg_i[idx];
  assign pol_o   = valid_o & pol_cfg_i[idx];
endmodule

// File: rtl/pir_irq_gen.sv
module pir_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic valid_i,
  input  logic edge_i,
  input  logic pol_i,
  output logic irq_o
);
  logic irq_q;
  logic pulse_q;
  logic accept;

  assign accept = evt_i & valid_i & ~pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (pulse_q) begin
      // pulse ends after one cycle; strobes here are dropped
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (accept) begin
      irq_q   <= edge_i ? 1'b1 : pol_i;
      pulse_q <= edge_i;
    end
  end

  assign irq_o = irq_q;

  // R7
  edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && edge_i) |=> irq_o);
  // R8
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && edge_i) |=> ##1 !irq_o);
  // R9
  level_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !edge_i) |=> (irq_o == $past(pol_i)));
  // R10
  out_range_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_q && evt_i && !valid_i) |=> $stable(irq_o));
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_q && !evt_i) |=> $stable(irq_o));
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pir_pkg::*;
#(
  parameter int LINE_BASE = 32,
  parameter int NUM_LINES = 32,
  parameter int PIN_W     = 2,
  localparam int LINE_W   = $clog2(LINE_BASE + NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DEVFN_W-1:0]   devfn_i,
  input  logic [PIN_W-1:0]     pin_i,
  input  logic                 evt_i,
  input  logic [NUM_LINES-1:0] edge_cfg_i,
  input  logic [NUM_LINES-1:0] pol_cfg_i,
  output logic [LINE_W-1:0]    line_o,
  output logic                 irq_o
);
  slot_t slot;
  logic  valid, edge_bit, pol_bit;
  logic  unused_fn;

  assign slot      = devfn_i[DEVFN_W-1:DEVFN_W-SLOT_W];
  assign unused_fn = ^devfn_i[DEVFN_W-SLOT_W-1:0];

  pir_route #(
    .LINE_BASE(LINE_BASE), .LINE_W(LINE_W), .PIN_W(PIN_W)
  ) i_route (
    .slot_i (slot),
    .pin_i  (pin_i),
    .line_o (line_o)
  );

  pir_cfg_sel #(
    .LINE_BASE(LINE_BASE), .NUM_LINES(NUM_LINES), .LINE_W(LINE_W)
  ) i_cfg_sel (
    .line_i     (line_o),
    .edge_cfg_i (edge_cfg_i),
    .pol_cfg_i  (pol_cfg_i),
    .valid_o    (valid),
    .edge_o     (edge_bit),
    .pol_o      (pol_bit)
  );

  pir_irq_gen i_irq_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .valid_i (valid),
    .edge_i  (edge_bit),
    .pol_i   (pol_bit),
    .irq_o   (irq_o)
  );

  // R6
  always_comb begin
    if (slot < SLOT_SB || slot > SLOT_EXP_HI) begin
      passthru_chk: assert (line_o == LINE_W'(pin_i));
    end
  end
endmodule

// File: tb/test_pci_irq_router.sv
`timescale 1ns/1ps
module test_pci_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  devfn = '0;
  logic [1:0]  pin = '0;
  logic        evt = 1'b0;
  logic [31:0] edge_cfg = '0;
  logic [31:0] pol_cfg = '0;
  logic [5:0]  line;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pci_irq_router i_pci_irq_router (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .devfn_i    (devfn),
    .pin_i      (pin),
    .evt_i      (evt),
    .edge_cfg_i (edge_cfg),
    .pol_cfg_i  (pol_cfg),
    .line_o     (line),
    .irq_o      (irq)
  );

  function automatic int exp_line(int slot, int p);
    if (slot == 5)                   return 32 + p;
    if (slot == 6)                   return 36;
    if (slot == 7)                   return 37;
    if (slot >= 8 && slot <= 12)     return 38 + (slot - 8) + p;
    return p;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // set inputs at falling edge
  task automatic put(int slot, int fn, int p, bit e);
    @(negedge clk);
    devfn = 8'((slot << 3) | fn);
    pin   = 2'(p);
    evt   = e;
  endtask

  // let the next rising edge take effect, then sample
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    #2;
    check("R1 reset", int'(irq), 0);
    put(0, 0, 0, 0);
    rst_n = 1'b1;
    step();
    check("R1 after release", int'(irq), 0);
  endtask

  task automatic t_route();
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        put(s, 0, p, 0);
        #1;
        if (s == 5)                   check("R3 slot5", int'(line), exp_line(s, p));
        else if (s == 6 || s == 7)    check("R4 slot6/7", int'(line), exp_line(s, p));
        else if (s >= 8 && s <= 12)   check("R5 slots8-12", int'(line), exp_line(s, p));
        else                          check("R6 passthru", int'(line), exp_line(s, p));
      end
    end
  endtask

  task automatic t_fn_bits();
    for (int f = 0; f < 8; f++) begin
      put(9, f, 2, 0);
      #1;
      check("R2 fn bits", int'(line), 38 + 1 + 2);
    end
  endtask

  task automatic t_edge();
    edge_cfg = 32'h0000_0004;   // line 34
    pol_cfg  = 32'h0;
    put(5, 0, 2, 1);
    step();
    check("R7 pulse high", int'(irq), 1);
    put(5, 0, 2, 0);
    step();
    check("R7 pulse one cycle", int'(irq), 0);
    step();
    check("R7 stays low", int'(irq), 0);
  endtask

  task automatic t_edge_retrig();
    edge_cfg = 32'h0000_2000;   // line 45: slot 12 pin 3
    put(12, 0, 3, 1);
    step();
    check("R8 pulse start", int'(irq), 1);
    step();                      // strobe still high during pulse
    check("R8 not lengthened", int'(irq), 0);
    put(12, 0, 3, 0);
    step();
    check("R8 low after", int'(irq), 0);
  endtask

  task automatic t_level();
    edge_cfg = 32'h0;
    pol_cfg  = 32'h0000_0020;   // line 37
    put(7, 0, 1, 1);
    step();
    check("R9 level high", int'(irq), 1);
    put(7, 0, 1, 0);
    step();
    check("R9 held", int'(irq), 1);
    pol_cfg = 32'h0;            // changed without strobe
    step();
    check("R11 cfg change no strobe", int'(irq), 1);
    put(6, 0, 0, 1);            // line 36, pol 0
    step();
    check("R9 level low", int'(irq), 0);
    put(6, 0, 0, 0);
  endtask

  task automatic t_out_range();
    edge_cfg = 32'h0;
    pol_cfg  = 32'hFFFF_FFFF;
    put(8, 0, 0, 1);            // line 38 -> high
    step();
    check("R9 set high", int'(irq), 1);
    pol_cfg  = 32'h0;
    edge_cfg = 32'hFFFF_FFFF;
    put(3, 0, 3, 1);            // line 3: outside bank
    #1;
    check("R10 line", int'(line), 3);
    step();
    check("R10 unchanged high", int'(irq), 1);
    put(20, 0, 1, 1);
    step();
    check("R10 unchanged again", int'(irq), 1);
    put(20, 0, 1, 0);
    step();
    check("R11 idle hold", int'(irq), 1);
  endtask

  initial begin
    t_reset();
    t_route();
    t_fn_bits();
    t_edge();
    t_edge_retrig();
    t_level();
    t_out_range();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule